// File: doc/BRIEF.md
# DMA control byte decoder

This block sits behind the single control port of a DMA controller and turns the CPU's byte stream into register contents and command strobes. Each byte is either a leading byte or a follow-on parameter byte. A leading byte is sorted into one of six groups: transfer control, port configuration, event control, mode, ready control, or command. The group is chosen from bit 7 and bits 1:0. Some bits of a leading byte announce which parameter bytes come next, and those announcements are kept in a short ordered queue of targets. Each later write goes to the target at the head of the queue. One target, the interrupt-control byte, extends the queue while it is being received. It can add a pulse byte and a vector byte behind any entries still waiting.

Control is a two-state machine. In `S_LEAD` every write is decoded as a leading byte. The transition *announce* goes to `S_PARAM` when that byte queues at least one parameter. In `S_PARAM` every write is routed to the head target. The transition *drain* returns to `S_LEAD` when the last queued entry is consumed and nothing is appended. Command strobes are registered and are high for exactly one cycle after the write that caused them. Transfer execution belongs to a separate engine, which consumes the strobes and registers.

Top module: `dma_ctrl_decoder`

## Requirements
- R1: After reset all parameter registers, `xfer_mode`, `dma_en`, `irq_en` and all strobes are 0, and the next write is decoded as a leading byte.
- R2: A leading byte with bit7=0 and bits1:0≠0 is stored in `xfer_ctrl`. Its bits 3, 4, 5 and 6 queue, in that order, `addr_a[7:0]`, `addr_a[15:8]`, `blk_len[7:0]` and `blk_len[15:8]`. Bits that are clear queue nothing.
- R3: A leading byte with bit7=0 and bits1:0=0 is stored in `port_a_cfg` when bit2=1, and in `port_b_cfg` otherwise. Its bit6 queues one timing byte, which is discarded and has no effect.
- R4: A leading byte with bit7=1 and bits1:0=0 sets `irq_en` to its bit5 and `dma_en` to its bit6. Its bit3 queues `mask_val` and its bit4 queues `match_val`, in that order.
- R5: A leading byte with bit7=1 and bits1:0=1 and bits6:5≠11 is stored in `mode_ctrl`, and `xfer_mode` takes bits6:5. Its bits 2, 3 and 4 queue `addr_b[7:0]`, `addr_b[15:8]` and `int_ctrl`, in that order. When bits6:5=11 the byte is ignored and queues nothing.
- R6: When `int_ctrl` is received, its bit3 appends an `int_pulse` entry and its bit4 then appends an `int_vector` entry. Both go behind the entries still queued.
- R7: A leading byte with bit7=1 and bits1:0=2 is stored in `ready_ctrl` only when its bits 6 and 2 are both 0. Otherwise it is ignored.
- R8: A leading byte with bit7=1 and bits1:0=3 is a command selected by bits6:2. 0x87 sets `dma_en`. 0xCF pulses `load_p`. 0xD3 pulses `cont_p` and sets `dma_en`. 0x8B pulses `stat_clr_p`. 0xB3 pulses `frdy_p`. 0x83 and unlisted codes have no other effect.
- R9: Command 0xAB sets `irq_en` and command 0xAF clears it. Command 0xC3 clears `xfer_ctrl[1:0]` and `irq_en`.
- R10: Command 0xBB queues a read-mask byte. Receiving it stores `read_mask` and pulses `rdseq_p`. Command 0xBF sets `read_mask` to 1 and pulses `rdseq_p`. Command 0xA7 pulses `rdseq_p`.
- R11: Every write clears `dma_en`, unless that same write sets it.
- R12: While parameters are queued, every write is stored as a parameter and never decoded as a command. The queue holds at most 6 entries, and leading-byte decoding resumes only once it is empty.
- R13: Strobes are high for exactly one cycle, beginning at the clock edge that samples the write, and at most one strobe is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control-port write strobe |
| wr_data | input | 8 | Control-port write data |
| xfer_ctrl | output | 8 | Transfer-control leading byte |
| addr_a | output | 16 | Port A start address |
| blk_len | output | 16 | Block length |
| port_a_cfg | output | 8 | Port A configuration byte |
| port_b_cfg | output | 8 | Port B configuration byte |
| mask_val | output | 8 | Compare mask byte |
| match_val | output | 8 | Compare match byte |
| mode_ctrl | output | 8 | Mode leading byte |
| xfer_mode | output | 2 | Transfer mode field |
| addr_b | output | 16 | Port B start address |
| int_ctrl | output | 8 | Interrupt-control byte |
| int_pulse | output | 8 | Interrupt pulse byte |
| int_vector | output | 8 | Interrupt vector byte |
| ready_ctrl | output | 8 | Ready-control byte |
| read_mask | output | 8 | Read-back selection mask |
| dma_en | output | 1 | DMA enable |
| irq_en | output | 1 | Interrupt enable |
| load_p | output | 1 | Load counters strobe |
| cont_p | output | 1 | Continue strobe |
| stat_clr_p | output | 1 | Clear status flags strobe |
| rdseq_p | output | 1 | Start read sequence strobe |
| frdy_p | output | 1 | Force ready strobe |

## Verification
Two of the block's functions meet in one cycle when the interrupt-control byte arrives. The head entry is popped and up to two new entries are appended, so the queue removes one entry and adds two on the same edge. The bench provokes this by sending mode bytes that queue the interrupt-control byte with both append bits set and with only the vector bit set. It judges the result by where the following bytes land, and it checks that a command byte sent afterwards is decoded as a command. The other collision is between the enable clear caused by every write and an enable set caused by the same byte. It is exercised by back-to-back enable, continue and event-control bytes, each followed by a byte that does not set the enable.

// File: rtl/dmadec_pkg.sv
package dmadec_pkg;

    localparam int LEAD_SLOTS = 4;
    localparam int APP_SLOTS  = 2;

    typedef enum logic [3:0] {
        T_NONE, T_A_LO, T_A_HI, T_LEN_LO, T_LEN_HI, T_TIMING,
        T_MASK, T_MATCH, T_B_LO, T_B_HI, T_INTCTL, T_PULSE,
        T_VECTOR, T_RDMASK
    } tgt_t;

    typedef enum logic {
        S_LEAD,
        S_PARAM
    } st_t;

    typedef enum logic [2:0] {
        G_NONE, G_XFER, G_PORT, G_EVENT, G_MODE, G_READY, G_CMD
    } grp_t;

    // command codes taken from bits 6:2 of the command byte
    localparam logic [4:0] C_DISABLE = 5'h00;
    localparam logic [4:0] C_ENABLE  = 5'h01;
    localparam logic [4:0] C_CLRSTAT = 5'h02;
    localparam logic [4:0] C_RDSEQ   = 5'h09;
    localparam logic [4:0] C_IRQON   = 5'h0A;
    localparam logic [4:0] C_IRQOFF  = 5'h0B;
    localparam logic [4:0] C_FRDY    = 5'h0C;
    localparam logic [4:0] C_RDMASK  = 5'h0E;
    localparam logic [4:0] C_RDSTAT  = 5'h0F;
    localparam logic [4:0] C_RESET   = 5'h10;
    localparam logic [4:0] C_LOAD    = 5'h13;
    localparam logic [4:0] C_CONT    = 5'h14;

endpackage

// File: rtl/dmadec_classify.sv
module dmadec_classify
    import dmadec_pkg::*;
#(
    parameter int DW = 8,
    localparam int LCW = $clog2(LEAD_SLOTS + 1)
) (
    input  logic [DW-1:0]  lead,
    output grp_t           grp,
    output logic [4:0]     cmd,
    output tgt_t           ent [LEAD_SLOTS],
    output logic [LCW-1:0] cnt
);

    tgt_t                  cand [LEAD_SLOTS];
    logic [LEAD_SLOTS-1:0] cv;
    int                    n;

    always_comb begin
        grp = G_NONE;
        cmd = lead[6:2];
        cv  = '0;
        for (int i = 0; i < LEAD_SLOTS; i++) cand[i] = T_NONE;

        if (!lead[7]) begin
            if (lead[1:0] != 2'b00) begin
                grp  = G_XFER;
                cand = '{T_A_LO, T_A_HI, T_LEN_LO, T_LEN_HI};
                cv   = lead[6:3];
            end else begin
                grp     = G_PORT;
                cand[0] = T_TIMING;
                cv[0]   = lead[6];
            end
        end else begin
            unique case (lead[1:0])
                2'b00: begin
                    grp     = G_EVENT;
                    cand[0] = T_MASK;
                    cand[1] = T_MATCH;
                    cv[1:0] = lead[4:3];
                end
                2'b01: begin
                    if (lead[6:5] != 2'b11) begin
                        grp     = G_MODE;
                        cand[0] = T_B_LO;
                        cand[1] = T_B_HI;
                        cand[2] = T_INTCTL;
                        cv[2:0] = lead[4:2];
                    end
                end
                2'b10: begin
                    if (!lead[6] && !lead[2]) grp = G_READY;
                end
                2'b11: begin
                    grp = G_CMD;
                    if (lead[6:2] == C_RDMASK) begin
                        cand[0] = T_RDMASK;
                        cv[0]   = 1'b1;
                    end
                end
            endcase
        end

        // pack the announced targets into consecutive slots, keeping order
        n = 0;
        for (int i = 0; i < LEAD_SLOTS; i++) ent[i] = T_NONE;
        for (int i = 0; i < LEAD_SLOTS; i++) begin
            if (cv[i]) begin
                ent[n[1:0]] = cand[i];
                n = n + 1;
            end
        end
        cnt = LCW'(n);
    end

endmodule

// File: rtl/dmadec_queue.sv
module dmadec_queue
    import dmadec_pkg::*;
#(
    parameter int DEPTH = 6,
    localparam int CW  = $clog2(DEPTH + 1),
    localparam int LCW = $clog2(LEAD_SLOTS + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [LCW-1:0] load_cnt,
    input  tgt_t           load_ent [LEAD_SLOTS],
    input  logic           pop,
    input  logic [1:0]     app_cnt,
    input  tgt_t           app_ent [APP_SLOTS],
    output tgt_t           head,
    output logic [CW-1:0]  count
);

    tgt_t          slot_q [DEPTH];
    tgt_t          slot_n [DEPTH];
    logic [CW-1:0] cnt_q, cnt_n;
    int            rem;

    always_comb begin
        slot_n = slot_q;
        cnt_n  = cnt_q;
        rem    = 0;
        if (load) begin
            for (int i = 0; i < DEPTH; i++) slot_n[i] = T_NONE;
            for (int i = 0; i < LEAD_SLOTS; i++) slot_n[i] = load_ent[i];
            cnt_n = CW'(load_cnt);
        end else if (pop) begin
            rem = int'(cnt_q) - 1;
            for (int i = 0; i < DEPTH - 1; i++) slot_n[i] = slot_q[i + 1];
            slot_n[DEPTH-1] = T_NONE;
            for (int j = 0; j < APP_SLOTS; j++) begin
                if (j < int'(app_cnt) && rem + j < DEPTH) slot_n[rem + j] = app_ent[j];
            end
            cnt_n = CW'(rem + int'(app_cnt));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= T_NONE;
            cnt_q <= '0;
        end else begin
            slot_q <= slot_n;
            cnt_q  <= cnt_n;
        end
    end

    assign head  = slot_q[0];
    assign count = cnt_q;

endmodule

// File: rtl/dma_ctrl_decoder.sv
module dma_ctrl_decoder
    import dmadec_pkg::*;
#(
    parameter int DW     = 8,
    parameter int QDEPTH = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [DW-1:0]   wr_data,
    output logic [DW-1:0]   xfer_ctrl,
    output logic [2*DW-1:0] addr_a,
    output logic [2*DW-1:0] blk_len,
    output logic [DW-1:0]   port_a_cfg,
    output logic [DW-1:0]   port_b_cfg,
    output logic [DW-1:0]   mask_val,
    output logic [DW-1:0]   match_val,
    output logic [DW-1:0]   mode_ctrl,
    output logic [1:0]      xfer_mode,
    output logic [2*DW-1:0] addr_b,
    output logic [DW-1:0]   int_ctrl,
    output logic [DW-1:0]   int_pulse,
    output logic [DW-1:0]   int_vector,
    output logic [DW-1:0]   ready_ctrl,
    output logic [DW-1:0]   read_mask,
    output logic            dma_en,
    output logic            irq_en,
    output logic            load_p,
    output logic            cont_p,
    output logic            stat_clr_p,
    output logic            rdseq_p,
    output logic            frdy_p
);

    localparam int QCW = $clog2(QDEPTH + 1);
    localparam int LCW = $clog2(LEAD_SLOTS + 1);

    st_t            state_q, state_n;
    logic           in_param;
    grp_t           grp;
    logic [4:0]     cmd;
    tgt_t           lead_ent [LEAD_SLOTS];
    logic [LCW-1:0] lead_cnt;
    tgt_t           head;
    logic [QCW-1:0] q_count;
    logic           q_load, q_pop;
    logic [1:0]     app_cnt;
    tgt_t           app_ent [APP_SLOTS];

    assign in_param = (state_q == S_PARAM);

    dmadec_classify #(.DW(DW)) u_cls (
        .lead (wr_data),
        .grp  (grp),
        .cmd  (cmd),
        .ent  (lead_ent),
        .cnt  (lead_cnt)
    );

    // entries appended by the interrupt-control byte
    always_comb begin
        app_cnt    = 2'd0;
        app_ent[0] = T_NONE;
        app_ent[1] = T_NONE;
        if (in_param && head == T_INTCTL) begin
            if (wr_data[3]) begin
                app_ent[0] = T_PULSE;
                app_cnt    = 2'd1;
            end
            if (wr_data[4]) begin
                app_ent[app_cnt[0]] = T_VECTOR;
                app_cnt = app_cnt + 2'd1;
            end
        end
    end

    assign q_load = wr_en && !in_param && (lead_cnt != '0);
    assign q_pop  = wr_en && in_param;

    dmadec_queue #(.DEPTH(QDEPTH)) u_q (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (q_load),
        .load_cnt (lead_cnt),
        .load_ent (lead_ent),
        .pop      (q_pop),
        .app_cnt  (app_cnt),
        .app_ent  (app_ent),
        .head     (head),
        .count    (q_count)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_LEAD;
        else        state_q <= state_n;
    end

    // transitions: announce (S_LEAD -> S_PARAM), drain (S_PARAM -> S_LEAD)
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_LEAD:  if (q_load) state_n = S_PARAM;
            S_PARAM: if (q_pop && q_count == QCW'(1) && app_cnt == 2'd0) state_n = S_LEAD;
        endcase
    end

    // outputs and parameter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_ctrl  <= '0;
            addr_a     <= '0;
            blk_len    <= '0;
            port_a_cfg <= '0;
            port_b_cfg <= '0;
            mask_val   <= '0;
            match_val  <= '0;
            mode_ctrl  <= '0;
            xfer_mode  <= '0;
            addr_b     <= '0;
            int_ctrl   <= '0;
            int_pulse  <= '0;
            int_vector <= '0;
            ready_ctrl <= '0;
            read_mask  <= '0;
            dma_en     <= 1'b0;
            irq_en     <= 1'b0;
            load_p     <= 1'b0;
            cont_p     <= 1'b0;
            stat_clr_p <= 1'b0;
            rdseq_p    <= 1'b0;
            frdy_p     <= 1'b0;
        end else begin
            load_p     <= 1'b0;
            cont_p     <= 1'b0;
            stat_clr_p <= 1'b0;
            rdseq_p    <= 1'b0;
            frdy_p     <= 1'b0;
            if (wr_en) begin
                dma_en <= 1'b0;
                if (in_param) begin
                    case (head)
                        T_A_LO:   addr_a[DW-1:0]     <= wr_data;
                        T_A_HI:   addr_a[2*DW-1:DW]  <= wr_data;
                        T_LEN_LO: blk_len[DW-1:0]    <= wr_data;
                        T_LEN_HI: blk_len[2*DW-1:DW] <= wr_data;
                        T_MASK:   mask_val           <= wr_data;
                        T_MATCH:  match_val          <= wr_data;
                        T_B_LO:   addr_b[DW-1:0]     <= wr_data;
                        T_B_HI:   addr_b[2*DW-1:DW]  <= wr_data;
                        T_INTCTL: int_ctrl           <= wr_data;
                        T_PULSE:  int_pulse          <= wr_data;
                        T_VECTOR: int_vector         <= wr_data;
                        T_RDMASK: begin
                            read_mask <= wr_data;
                            rdseq_p   <= 1'b1;
                        end
                        default: ;
                    endcase
                end else begin
                    unique case (grp)
                        G_XFER: xfer_ctrl <= wr_data;
                        G_PORT: begin
                            if (wr_data[2]) port_a_cfg <= wr_data;
                            else            port_b_cfg <= wr_data;
                        end
                        G_EVENT: begin
                            irq_en <= wr_data[5];
                            dma_en <= wr_data[6];
                        end
                        G_MODE: begin
                            mode_ctrl <= wr_data;
                            xfer_mode <= wr_data[6:5];
                        end
                        G_READY: ready_ctrl <= wr_data;
                        G_CMD: begin
                            case (cmd)
                                C_ENABLE:  dma_en     <= 1'b1;
                                C_CLRSTAT: stat_clr_p <= 1'b1;
                                C_RDSEQ:   rdseq_p    <= 1'b1;
                                C_IRQON:   irq_en     <= 1'b1;
                                C_IRQOFF:  irq_en     <= 1'b0;
                                C_FRDY:    frdy_p     <= 1'b1;
                                C_RDSTAT: begin
                                    read_mask <= DW'(1);
                                    rdseq_p   <= 1'b1;
                                end
                                C_RESET: begin
                                    xfer_ctrl[1:0] <= 2'b00;
                                    irq_en         <= 1'b0;
                                end
                                C_LOAD: load_p <= 1'b1;
                                C_CONT: begin
                                    cont_p <= 1'b1;
                                    dma_en <= 1'b1;
                                end
                                default: ;
                            endcase
                        end
                        G_NONE: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/dmadec_chk.sv
module dmadec_chk #(
    parameter int QCW = 3,
    parameter int QDEPTH = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wr_en,
    input logic [7:0]     wr_data,
    input logic           in_param,
    input logic [QCW-1:0] q_count,
    input logic           dma_en,
    input logic           irq_en,
    input logic           load_p,
    input logic           cont_p,
    input logic           stat_clr_p,
    input logic           rdseq_p,
    input logic           frdy_p
);

    // R12
    param_mode_matches_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_param == (q_count != '0));

    // R12
    queue_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= QCW'(QDEPTH));

    // R11
    param_write_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && in_param |=> !dma_en);

    // R9
    irq_off_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !in_param && wr_data == 8'hAF |=> !irq_en);

    // R8
    load_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !in_param && wr_data == 8'hCF |=> load_p);

    // R13
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_p, cont_p, stat_clr_p, rdseq_p, frdy_p}));

    // R13
    strobe_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_p || cont_p || stat_clr_p || rdseq_p || frdy_p) |-> $past(wr_en));

    // R13
    strobe_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_p && !wr_en |=> !load_p);

endmodule

bind dma_ctrl_decoder dmadec_chk #(.QCW(QCW), .QDEPTH(QDEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .in_param   (in_param),
    .q_count    (q_count),
    .dma_en     (dma_en),
    .irq_en     (irq_en),
    .load_p     (load_p),
    .cont_p     (cont_p),
    .stat_clr_p (stat_clr_p),
    .rdseq_p    (rdseq_p),
    .frdy_p     (frdy_p)
);

// File: tb/dma_ctrl_decoder_test.sv
`timescale 1ns/1ps
module dma_ctrl_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic [7:0]  xfer_ctrl, port_a_cfg, port_b_cfg, mask_val, match_val, mode_ctrl;
    logic [7:0]  int_ctrl, int_pulse, int_vector, ready_ctrl, read_mask;
    logic [15:0] addr_a, blk_len, addr_b;
    logic [1:0]  xfer_mode;
    logic        dma_en, irq_en, load_p, cont_p, stat_clr_p, rdseq_p, frdy_p;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dma_ctrl_decoder uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .xfer_ctrl(xfer_ctrl), .addr_a(addr_a), .blk_len(blk_len),
        .port_a_cfg(port_a_cfg), .port_b_cfg(port_b_cfg),
        .mask_val(mask_val), .match_val(match_val), .mode_ctrl(mode_ctrl),
        .xfer_mode(xfer_mode), .addr_b(addr_b), .int_ctrl(int_ctrl),
        .int_pulse(int_pulse), .int_vector(int_vector), .ready_ctrl(ready_ctrl),
        .read_mask(read_mask), .dma_en(dma_en), .irq_en(irq_en),
        .load_p(load_p), .cont_p(cont_p), .stat_clr_p(stat_clr_p),
        .rdseq_p(rdseq_p), .frdy_p(frdy_p)
    );

    // {data, dma_en, irq_en, load, cont, stat_clr, rdseq, frdy}
    localparam int NV = 15;
    localparam logic [14:0] VEC [NV] = '{
        {8'h87, 2'b10, 5'b00000},   // R8 enable
        {8'hAB, 2'b01, 5'b00000},   // R9 irq on, R11 clears en
        {8'h87, 2'b11, 5'b00000},   // R8
        {8'hAF, 2'b00, 5'b00000},   // R9 irq off
        {8'hCF, 2'b00, 5'b10000},   // R8 load
        {8'hD3, 2'b10, 5'b01000},   // R8 continue
        {8'h8B, 2'b00, 5'b00100},   // R8 status clear
        {8'hA7, 2'b00, 5'b00010},   // R10 read sequence
        {8'hB3, 2'b00, 5'b00001},   // R8 force ready
        {8'hBF, 2'b00, 5'b00010},   // R10 read status
        {8'hE0, 2'b11, 5'b00000},   // R4 event group
        {8'hAF, 2'b00, 5'b00000},   // R9
        {8'hC0, 2'b10, 5'b00000},   // R4
        {8'hC3, 2'b00, 5'b00000},   // R9 reset cmd, R11
        {8'h83, 2'b00, 5'b00000}    // R8 disable
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, return at the next falling edge (after the sampling edge)
    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 regs", {xfer_ctrl, port_a_cfg, port_b_cfg, mode_ctrl}, 32'h0);
        chk("R1 addr", {addr_a, addr_b}, 32'h0);
        chk("R1 ctl", {xfer_mode, dma_en, irq_en, load_p, cont_p, stat_clr_p, rdseq_p, frdy_p}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][14:7]);
            chk($sformatf("R8 vec%0d", i),
                {dma_en, irq_en, load_p, cont_p, stat_clr_p, rdseq_p, frdy_p}, 32'(VEC[i][6:0]));
        end
        chk("R10 rdstat mask", read_mask, 8'h01);
        chk("R9 c3 clears low bits", xfer_ctrl, 8'h00);

        // R2 full transfer group
        wr(8'h79); wr(8'h34); wr(8'h12); wr(8'h78); wr(8'h56);
        chk("R2 xfer_ctrl", xfer_ctrl, 8'h79);
        chk("R2 addr_a", addr_a, 16'h1234);
        chk("R2 blk_len", blk_len, 16'h5678);
        wr(8'h87);
        chk("R12 lead resumes", dma_en, 1'b1);
        wr(8'hC3);
        chk("R9 c3 xfer_ctrl", xfer_ctrl, 8'h78);
        chk("R11 c3 clears en", dma_en, 1'b0);

        // R2 sparse, R12 command-like data taken as parameter
        wr(8'h51); wr(8'hAB); wr(8'hCD);
        chk("R2 sparse addr_a", addr_a, 16'hAB34);
        chk("R2 sparse blk_len", blk_len, 16'hCD78);
        chk("R12 param not cmd", irq_en, 1'b0);

        // R3 port config, timing byte discarded
        wr(8'h44); wr(8'h87);
        chk("R3 port_a", port_a_cfg, 8'h44);
        chk("R3 timing ignored", dma_en, 1'b0);
        wr(8'h10);
        chk("R3 port_b", port_b_cfg, 8'h10);
        wr(8'h87);
        chk("R3 no queue", dma_en, 1'b1);

        // R4 mask and match
        wr(8'h98); wr(8'h0F); wr(8'hF0);
        chk("R4 mask", mask_val, 8'h0F);
        chk("R4 match", match_val, 8'hF0);
        chk("R4 en/irq", {dma_en, irq_en}, 2'b00);

        // R5 mode group, R6 both appends
        wr(8'hDD); wr(8'h11); wr(8'h22); wr(8'h18); wr(8'h33); wr(8'h44);
        chk("R5 mode_ctrl", mode_ctrl, 8'hDD);
        chk("R5 xfer_mode", xfer_mode, 2'd2);
        chk("R5 addr_b", addr_b, 16'h2211);
        chk("R6 int_ctrl", int_ctrl, 8'h18);
        chk("R6 pulse", int_pulse, 8'h33);
        chk("R6 vector", int_vector, 8'h44);
        wr(8'h87);
        chk("R6 queue drained", dma_en, 1'b1);

        // R5 ignored mode byte
        wr(8'hFD);
        chk("R5 ignored mode", {mode_ctrl, 6'b0, xfer_mode}, {8'hDD, 8'h02});
        wr(8'h87);
        chk("R5 ignored no queue", dma_en, 1'b1);

        // R7 ready group
        wr(8'h8A);
        chk("R7 stored", ready_ctrl, 8'h8A);
        wr(8'hCE);
        chk("R7 bit6 ignored", ready_ctrl, 8'h8A);
        wr(8'h8E);
        chk("R7 bit2 ignored", ready_ctrl, 8'h8A);

        // R10 read mask follow-on
        wr(8'hBB);
        chk("R10 bb no strobe", rdseq_p, 1'b0);
        wr(8'h7F);
        chk("R10 mask strobe", rdseq_p, 1'b1);
        chk("R10 mask value", read_mask, 8'h7F);
        @(negedge clk);
        chk("R13 strobe one cycle", rdseq_p, 1'b0);
        wr(8'hBF);
        chk("R10 bf mask", read_mask, 8'h01);

        // R6 vector-only append
        wr(8'h91); wr(8'h10); wr(8'h55);
        chk("R6 vec only int_ctrl", int_ctrl, 8'h10);
        chk("R6 vec only vector", int_vector, 8'h55);
        chk("R6 vec only pulse kept", int_pulse, 8'h33);
        wr(8'h87);
        chk("R6 vec only drained", dma_en, 1'b1);

        // R1 reset during a pending queue
        wr(8'h79); wr(8'h99);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset addr", addr_a, 16'h0);
        chk("R1 reset xfer", xfer_ctrl, 8'h0);
        wr(8'h87);
        chk("R1 lead after reset", dma_en, 1'b1);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R12 actual=hung expected=finished");
            summary();
            $finish;
        end
    end

endmodule